// File: doc/BRIEF.md
# Matrix Tile Slice Address Generator

This block turns a tile-slice reference into a byte offset inside a row-organised matrix storage. Every storage row is one maximum-length vector wide. The reference is made of an element size code, a four-bit field that carries both the tile number and an immediate slice index, a 32-bit slice register value, a row/column flag and the current vector length. The slice number is the register value plus the immediate. It is wrapped to the number of slices that a tile of that element size holds. It is then scaled by the stride that suits a row slice or a column slice. The tile's base row is added last.

In the same cycle the block also forms the memory address of a contiguous tile load or store: a 64-bit base plus an index scaled by the element size. A whole-row mode covers accesses that name a full storage row directly. The result is registered once and qualified by a valid flag.

Top module: `tile_slice_agen`

## Requirements
- R1: While reset is high and in the cycle after it is released, out_valid is 0.
- R2: Element size codes are 0=byte, 1=half, 2=word, 3=double, 4=quad. With k = 4 - size code, the tile number is field >> k and the immediate index is the low k bits of the field. For quad elements the immediate is 0 and the whole field is the tile number.
- R3: The slice number is the 32-bit sum of in_slice_reg and the immediate, wrapping modulo 2^32.
- R4: The slice number is reduced modulo (2^in_vl_log2 >> size code), with in_vl_log2 from 4 to 8. When that count is 1 (vector length 16 bytes with quad elements), the slice part of the offset is 0.
- R5: For a column slice (in_vertical=1) the offset is tile*256 + (wrapped slice << size code).
- R6: For a row slice (in_vertical=0) the offset is tile*256 + (wrapped slice << (size code + 8)).
- R7: Inputs are captured at a rising edge where in_valid is 1. The results appear on offset_out and addr_out after that edge, with out_valid=1. out_valid is 0 after an edge where in_valid was 0.
- R8: While in_valid is 0, offset_out and addr_out hold their last values, whatever the other inputs do.
- R9: addr_out is in_base + (in_step << size code), modulo 2^64.
- R10: When in_whole_row=1, in_esz and in_vertical are ignored. The access is handled as a byte-element row slice, so the tile is 0, the immediate is the whole field, and the address scale is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture request |
| in_esz | input | 3 | Element size code, 0 to 4 |
| in_field | input | 4 | Combined tile number and immediate slice index |
| in_slice_reg | input | 32 | Slice index register value |
| in_vertical | input | 1 | 1 = column slice, 0 = row slice |
| in_whole_row | input | 1 | Whole-row access mode |
| in_vl_log2 | input | 4 | log2 of the vector length in bytes, 4 to 8 |
| in_base | input | 64 | Load/store base address |
| in_step | input | 64 | Load/store index, scaled by the element size |
| out_valid | output | 1 | Results valid |
| offset_out | output | 17 | Byte offset of the slice in the storage |
| addr_out | output | 64 | Load/store memory address |

## Verification
The slice offset and the load/store address are both produced from one capture and share the element size. The bench therefore always drives a non-trivial base and step together with each slice reference. Both outputs are compared against independently computed values at the same sample point. Back-to-back captures with different sizes and modes, plus whole-row requests that also carry a conflicting size code, show whether either path picks up the size meant for the other or for the previous request.

// File: rtl/tsag_pkg.sv
package tsag_pkg;
    localparam int FIELD_W = 4;
    localparam int IDX_W   = 32;
    localparam int ADDR_W  = 64;
    localparam int VLC_W   = 4;

    typedef enum logic [2:0] {
        ESZ_BYTE  = 3'd0,
        ESZ_HALF  = 3'd1,
        ESZ_WORD  = 3'd2,
        ESZ_DWORD = 3'd3,
        ESZ_QUAD  = 3'd4
    } esz_e;

    typedef struct packed {
        esz_e esz;
        logic vertical;
    } slice_mode_t;

    // number of immediate bits in the combined field for a size
    function automatic logic [2:0] imm_bits(esz_e e);
        return (e >= ESZ_QUAD) ? 3'd0 : 3'(3'd4 - 3'(e));
    endfunction

    function automatic logic [FIELD_W-1:0] field_tile(esz_e e, logic [FIELD_W-1:0] f);
        return f >> imm_bits(e);
    endfunction

    function automatic logic [FIELD_W-1:0] field_imm(esz_e e, logic [FIELD_W-1:0] f);
        return f & ~({FIELD_W{1'b1}} << imm_bits(e));
    endfunction

    function automatic slice_mode_t resolve_mode(logic [2:0] raw, logic vert, logic whole);
        slice_mode_t m;
        if (whole) begin
            m.esz      = ESZ_BYTE;
            m.vertical = 1'b0;
        end else begin
            m.esz      = (raw > 3'd4) ? ESZ_QUAD : esz_e'(raw);
            m.vertical = vert;
        end
        return m;
    endfunction
endpackage

// File: rtl/tsag_field_split.sv
module tsag_field_split
    import tsag_pkg::*;
(
    input  esz_e               esz,
    input  logic [FIELD_W-1:0] field,
    output logic [FIELD_W-1:0] tile,
    output logic [FIELD_W-1:0] imm
);
    always_comb begin
        tile = field_tile(esz, field);
        imm  = field_imm(esz, field);
    end
endmodule

// File: rtl/tsag_slice_wrap.sv
module tsag_slice_wrap
    import tsag_pkg::*;
#(
    parameter int RS_LOG2 = 8,
    parameter int OFF_W   = 2 * RS_LOG2 + 1
) (
    input  esz_e               esz,
    input  logic               vertical,
    input  logic [FIELD_W-1:0] tile,
    input  logic [FIELD_W-1:0] imm,
    input  logic [IDX_W-1:0]   slice_reg,
    input  logic [VLC_W-1:0]   vl_log2,
    output logic [OFF_W-1:0]   offset
);
    localparam int SH_W = $clog2(RS_LOG2 + 5);

    logic [IDX_W-1:0]   slice_sum;
    logic [IDX_W-1:0]   keep_mask;
    logic [VLC_W-1:0]   vl_eff;
    logic [VLC_W-1:0]   keep_len;
    logic [IDX_W-1:0]   kept;
    logic [RS_LOG2-1:0] wrapped;
    logic [SH_W-1:0]    shamt;

    always_comb begin
        slice_sum = slice_reg + IDX_W'(imm);
        vl_eff    = (vl_log2 > VLC_W'(RS_LOG2)) ? VLC_W'(RS_LOG2) : vl_log2;
        keep_len  = (vl_eff > VLC_W'(esz)) ? (vl_eff - VLC_W'(esz)) : '0;
        keep_mask = ~({IDX_W{1'b1}} << keep_len);
        kept      = slice_sum & keep_mask;
        wrapped   = kept[RS_LOG2-1:0];
        shamt     = vertical ? SH_W'(esz) : (SH_W'(esz) + SH_W'(RS_LOG2));
        offset    = (OFF_W'(tile) << RS_LOG2) + (OFF_W'(wrapped) << shamt);
    end
endmodule

// File: rtl/tsag_mem_addr.sv
module tsag_mem_addr
    import tsag_pkg::*;
(
    input  esz_e              esz,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] step,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        addr = base + (step << esz);
    end
endmodule

// File: rtl/tile_slice_agen.sv
module tile_slice_agen
    import tsag_pkg::*;
#(
    parameter  int RS_LOG2 = 8,
    localparam int OFF_W   = 2 * RS_LOG2 + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [2:0]         in_esz,
    input  logic [FIELD_W-1:0] in_field,
    input  logic [IDX_W-1:0]   in_slice_reg,
    input  logic               in_vertical,
    input  logic               in_whole_row,
    input  logic [VLC_W-1:0]   in_vl_log2,
    input  logic [ADDR_W-1:0]  in_base,
    input  logic [ADDR_W-1:0]  in_step,
    output logic               out_valid,
    output logic [OFF_W-1:0]   offset_out,
    output logic [ADDR_W-1:0]  addr_out
);
    slice_mode_t        mode;
    logic [FIELD_W-1:0] tile;
    logic [FIELD_W-1:0] imm;
    logic [OFF_W-1:0]   slice_off;
    logic [ADDR_W-1:0]  mem_addr;

    always_comb begin
        mode = resolve_mode(in_esz, in_vertical, in_whole_row);
    end

    tsag_field_split u_split (
        .esz   (mode.esz),
        .field (in_field),
        .tile  (tile),
        .imm   (imm)
    );

    tsag_slice_wrap #(
        .RS_LOG2 (RS_LOG2),
        .OFF_W   (OFF_W)
    ) u_wrap (
        .esz       (mode.esz),
        .vertical  (mode.vertical),
        .tile      (tile),
        .imm       (imm),
        .slice_reg (in_slice_reg),
        .vl_log2   (in_vl_log2),
        .offset    (slice_off)
    );

    tsag_mem_addr u_addr (
        .esz  (mode.esz),
        .base (in_base),
        .step (in_step),
        .addr (mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            offset_out <= '0;
            addr_out   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                offset_out <= slice_off;
                addr_out   <= mem_addr;
            end
        end
    end
endmodule

// File: rtl/tsag_checker.sv
module tsag_checker
    import tsag_pkg::*;
#(
    parameter  int RS_LOG2 = 8,
    localparam int OFF_W   = 2 * RS_LOG2 + 1
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [2:0]         in_esz,
    input logic [FIELD_W-1:0] in_field,
    input logic               in_vertical,
    input logic               in_whole_row,
    input logic [ADDR_W-1:0]  in_base,
    input logic [ADDR_W-1:0]  in_step,
    input logic               out_valid,
    input logic [OFF_W-1:0]   offset_out,
    input logic [ADDR_W-1:0]  addr_out
);
    logic [FIELD_W-1:0] chk_tile;
    logic [2:0]         chk_scale;
    logic [ADDR_W-1:0]  chk_addr;
    logic               col_req;

    always_comb begin
        chk_tile  = in_field >> (3'd4 - in_esz);
        chk_scale = in_whole_row ? 3'd0 : in_esz;
        chk_addr  = in_base + (in_step << chk_scale);
        col_req   = in_vertical && !in_whole_row && (in_esz <= 3'd4);
    end

    // R7
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R7
    a_r7_idle_clears: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R8
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(offset_out) && $stable(addr_out)));
    // R5
    a_r5_col_tile: assert property (@(posedge clk) disable iff (rst)
        (in_valid && col_req) |=> ((offset_out >> RS_LOG2) == OFF_W'($past(chk_tile))));
    // R6
    a_r6_row_aligned: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !col_req) |=> (offset_out[RS_LOG2-1:0] == '0));
    // R9
    a_r9_addr: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_esz <= 3'd4)) |=> (addr_out == $past(chk_addr)));
endmodule

bind tile_slice_agen tsag_checker #(.RS_LOG2(RS_LOG2)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_esz       (in_esz),
    .in_field     (in_field),
    .in_vertical  (in_vertical),
    .in_whole_row (in_whole_row),
    .in_base      (in_base),
    .in_step      (in_step),
    .out_valid    (out_valid),
    .offset_out   (offset_out),
    .addr_out     (addr_out)
);

// File: tb/tile_slice_agen_test.sv
module tile_slice_agen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  in_esz;
    logic [3:0]  in_field;
    logic [31:0] in_slice_reg;
    logic        in_vertical;
    logic        in_whole_row;
    logic [3:0]  in_vl_log2;
    logic [63:0] in_base;
    logic [63:0] in_step;
    logic        out_valid;
    logic [16:0] offset_out;
    logic [63:0] addr_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tile_slice_agen uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_esz(in_esz),
        .in_field(in_field), .in_slice_reg(in_slice_reg),
        .in_vertical(in_vertical), .in_whole_row(in_whole_row),
        .in_vl_log2(in_vl_log2), .in_base(in_base), .in_step(in_step),
        .out_valid(out_valid), .offset_out(offset_out), .addr_out(addr_out)
    );

    // reference from the requirements
    function automatic logic [63:0] ref_offset(logic [2:0] e_in, logic [3:0] f,
            logic [31:0] s, logic v_in, logic w, logic [3:0] vl);
        int e = w ? 0 : int'(e_in);
        int v = w ? 0 : int'(v_in);
        longint unsigned tile = longint'(f) >> (4 - e);
        longint unsigned imm  = (e == 4) ? 0 : (longint'(f) % (longint'(1) << (4 - e)));
        longint unsigned sum  = (longint'(s) + imm) % (longint'(1) << 32);
        longint unsigned cnt  = (longint'(1) << vl) >> e;
        longint unsigned wr   = sum % cnt;
        longint unsigned sl   = v ? (wr << e) : (wr << (e + 8));
        return 64'(tile * 256 + sl);
    endfunction

    function automatic logic [63:0] ref_addr(logic [2:0] e, logic w, logic [63:0] b, logic [63:0] st);
        return b + (st << (w ? 3'd0 : e));
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_in(logic [2:0] e, logic [3:0] f, logic [31:0] s, logic v,
            logic w, logic [3:0] vl, logic [63:0] b, logic [63:0] st);
        in_esz = e; in_field = f; in_slice_reg = s; in_vertical = v;
        in_whole_row = w; in_vl_log2 = vl; in_base = b; in_step = st;
    endtask

    // one request, results checked after the capturing edge
    task automatic issue(string tag, logic [2:0] e, logic [3:0] f, logic [31:0] s,
            logic v, logic w, logic [3:0] vl, logic [63:0] b, logic [63:0] st);
        @(negedge clk);
        set_in(e, f, s, v, w, vl, b, st);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, 64'(out_valid), 64'd1);
        check({tag, " offset"}, 64'(offset_out), ref_offset(e, f, s, v, w, vl));
        check({tag, " addr"}, addr_out, ref_addr(e, w, b, st));
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0;
        set_in(0, 0, 0, 0, 0, 8, 0, 0);
        repeat (3) @(negedge clk);
        check("R1 valid in reset", 64'(out_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", 64'(out_valid), 64'd0);
    endtask

    task automatic t_column;
        // R2 R5: word, field 1110 -> tile 3, imm 2; slice 5+2=7 -> 768+28
        issue("R5 column word", 3'd2, 4'hE, 32'd5, 1'b1, 1'b0, 4'd8, 64'h100, 64'h2);
        check("R5 column word literal", 64'(offset_out), 64'd796);
        issue("R2 column half", 3'd1, 4'hB, 32'd40, 1'b1, 1'b0, 4'd7, 64'h0, 64'h9);
    endtask

    task automatic t_row;
        // R6 R3: same request as a row slice -> 768 + 7<<10
        issue("R6 row word", 3'd2, 4'hE, 32'd5, 1'b0, 1'b0, 4'd8, 64'h100, 64'h2);
        check("R6 row word literal", 64'(offset_out), 64'd7936);
        issue("R6 row double", 3'd3, 4'h7, 32'd3, 1'b0, 1'b0, 4'd6, 64'hFF, 64'h1);
    endtask

    task automatic t_wrap;
        // R3 R4: register sum wraps past 2^32, then modulo 16 slices
        issue("R3 sum wrap", 3'd0, 4'hF, 32'hFFFF_FFF3, 1'b0, 1'b0, 4'd4, 64'h0, 64'h0);
        check("R3 sum wrap literal", 64'(offset_out), 64'd512);
        issue("R4 modulo", 3'd1, 4'h2, 32'd1000, 1'b1, 1'b0, 4'd5, 64'h0, 64'h0);
    endtask

    task automatic t_single_slice;
        // R4: 16-byte vector with quad elements -> one slice only
        issue("R4 single slice", 3'd4, 4'd9, 32'd77, 1'b0, 1'b0, 4'd4, 64'h0, 64'h0);
        check("R4 single slice literal", 64'(offset_out), 64'd2304);
        issue("R4 single slice col", 3'd4, 4'd15, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'd4, 64'h0, 64'h0);
    endtask

    task automatic t_whole_row;
        // R10: size code 3 and column flag ignored
        issue("R10 whole row", 3'd3, 4'd5, 32'd10, 1'b1, 1'b1, 4'd6, 64'h1000, 64'h3);
        check("R10 whole row offset literal", 64'(offset_out), 64'd3840);
        check("R10 whole row addr literal", addr_out, 64'h1003);
    endtask

    task automatic t_addr;
        issue("R9 addr dword", 3'd3, 4'h1, 32'd0, 1'b0, 1'b0, 4'd8, 64'h1000, 64'h3);
        check("R9 addr literal", addr_out, 64'h1018);
        issue("R9 addr wrap", 3'd4, 4'h0, 32'd0, 1'b1, 1'b0, 4'd8,
              64'hFFFF_FFFF_FFFF_FFF0, 64'h2);
        check("R9 addr wrap literal", addr_out, 64'h10);
    endtask

    task automatic t_hold;
        logic [16:0] off0;
        logic [63:0] adr0;
        issue("R8 setup", 3'd2, 4'h6, 32'd9, 1'b0, 1'b0, 4'd8, 64'h500, 64'h7);
        off0 = offset_out; adr0 = addr_out;
        set_in(3'd0, 4'hF, 32'h1234, 1'b1, 1'b1, 4'd5, 64'hDEAD, 64'hBEEF);
        repeat (2) @(negedge clk);
        check("R8 hold offset", 64'(offset_out), 64'(off0));
        check("R8 hold addr", addr_out, adr0);
        check("R7 idle valid", 64'(out_valid), 64'd0);
    endtask

    task automatic t_stream;
        // R7: back-to-back requests, each result one edge later
        @(negedge clk);
        set_in(3'd1, 4'h9, 32'd3, 1'b1, 1'b0, 4'd8, 64'h40, 64'h5);
        in_valid = 1'b1;
        @(negedge clk);
        check("R7 stream a off", 64'(offset_out), ref_offset(3'd1, 4'h9, 32'd3, 1'b1, 1'b0, 4'd8));
        check("R7 stream a addr", addr_out, ref_addr(3'd1, 1'b0, 64'h40, 64'h5));
        set_in(3'd4, 4'h3, 32'd8, 1'b0, 1'b1, 4'd7, 64'h80, 64'h6);
        @(negedge clk);
        check("R7 stream b off", 64'(offset_out), ref_offset(3'd4, 4'h3, 32'd8, 1'b0, 1'b1, 4'd7));
        check("R7 stream b addr", addr_out, ref_addr(3'd4, 1'b1, 64'h80, 64'h6));
        check("R7 stream b valid", 64'(out_valid), 64'd1);
        in_valid = 1'b0;
        @(negedge clk);
        check("R7 stream end valid", 64'(out_valid), 64'd0);
    endtask

    task automatic t_sweep;
        for (int e = 0; e <= 4; e++) begin
            for (int vl = 4; vl <= 8; vl++) begin
                for (int v = 0; v < 2; v++) begin
                    issue("R4 R5 R6 sweep", 3'(e), 4'(e * 3 + vl), 32'(vl * 37 + e),
                          1'(v), 1'b0, 4'(vl), 64'(vl * 4096), 64'(e + 1));
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_column();
        t_row();
        t_wrap();
        t_single_slice();
        t_whole_row();
        t_addr();
        t_hold();
        t_stream();
        t_sweep();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule